// File: doc/BRIEF.md
# Programmable Count-Down Interrupt Timer

This block is a per-processor interrupt timer. Software reaches it through a small word-wide register port. It sets up a timer entry that holds the interrupt vector, a mask bit and a counting mode. It picks a clock divider and then writes a start value. The block divides its clock by a power of two and lowers a current count by one on every divided tick. When the count runs out, the block emits a one-cycle interrupt request that carries the programmed vector.

Two counting modes exist. In single-shot mode the count halts at zero until software writes a new start value. In repeating mode the count reloads from the start value and keeps running. A third encoding, the deadline mode, is accepted and behaves as single-shot. Writing a start value of zero halts the timer. Masking hides the request but does not stop the counting.

Register map, selected by `cfg_addr`:

| Address | Register |
|---------|----------|
| 0 | timer entry |
| 1 | divider |
| 2 | start value |
| 3 | current count, read-only |

Read data is combinational from `cfg_addr` with the default parameters.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the registers read back as follows: timer entry 0x0001_0000 (masked, vector 0, single-shot), divider 0, start value 0 and current count 0. `irq_pulse` is low.
- R2: The timer entry stores the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17, where 00 is single-shot, 01 is repeating and 10 is deadline. Every other bit reads as zero.
- R3: The divider register keeps only bits 3, 1 and 0, and all other bits read as zero. The code {bit3,bit1,bit0} selects the divide ratio D: codes 000 to 110 give D = 2^(code+1) (so 011 gives 16), and code 111 gives D = 1.
- R4: Writing a non-zero start value N loads N into the current count and starts the timer. Call the clock edge that takes the write edge 0. After edge m the current count reads N - floor(m/D) for every m below N*D.
- R5: Expiry happens on the edge where the count steps from 1 to 0, which is edge N*D. `irq_pulse` is high for the one cycle after that edge, and `irq_vec` then equals the entry vector. `irq_vec` is zero whenever `irq_pulse` is low.
- R6: In single-shot mode the current count stays at zero after expiry and no further request is raised.
- R7: In repeating mode expiry reloads the current count with N. A request follows every N*D edges.
- R8: With the mask bit set, expiry raises no request, while counting and reloading go on as usual.
- R9: Writing zero to the start value halts the timer. The current count reads zero and no request follows.
- R10: Writes to the current-count address have no effect.
- R11: Writing a new non-zero start value while the timer is running restarts the count from the new value and the divider phase.
- R12: The deadline mode encoding behaves exactly as single-shot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register select: 0 entry, 1 divider, 2 start value, 3 current count |
| cfg_wdata | input | CNT_W | Write data |
| cfg_rdata | output | CNT_W | Read data for `cfg_addr` |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vec | output | VEC_W | Vector carried with the request, zero otherwise |

## Verification
A wrong prescaler phase or a wrong decrement shows up at once in the current-count readback, because the bench compares that count on every cycle of every run. A divider that is off by one tick becomes visible within D cycles of the start write. A wrong reload, mask or halt decision shows on `irq_pulse` in the exact cycle after the expiry edge. That cycle is either missing its pulse or carries a pulse in a cycle where none is due. A stale vector shows on `irq_vec` in that same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // register selects (low address bits)
   localparam logic [1:0] A_ENTRY = 2'd0;
   localparam logic [1:0] A_DIV   = 2'd1;
   localparam logic [1:0] A_INIT  = 2'd2;
   localparam logic [1:0] A_CUR   = 2'd3;

   // field positions inside the timer entry
   localparam int MASK_BIT  = 16;
   localparam int MODE_LO   = 17;
   localparam int ENTRY_TOP = 18;

   // largest divider shift (divide by 128)
   localparam int MAX_SHIFT = 7;
   localparam int PRE_W     = MAX_SHIFT;

   typedef enum logic [1:0] {
      TM_SINGLE   = 2'b00,
      TM_REPEAT   = 2'b01,
      TM_DEADLINE = 2'b10,
      TM_RSVD     = 2'b11
   } tmr_mode_e;

   // {bit3,bit1,bit0} code to shift amount: 111 -> 0, else code+1
   function automatic logic [2:0] code_to_shift(input logic [2:0] code);
      return (code == 3'b111) ? 3'd0 : code + 3'd1;
   endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 2,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cur_val,
   output logic [CNT_W-1:0]  rdata,
   output logic [VEC_W-1:0]  vec,
   output logic              mask,
   output logic              periodic,
   output logic [2:0]        div_code,
   output logic [CNT_W-1:0]  init_val,
   output logic              arm,
   output logic              stop
);
   tmr_mode_e  mode_q;
   logic       sel_entry, sel_div, sel_init;
   logic [CNT_W-1:0] rd_next;

   assign sel_entry = (addr == ADDR_W'(A_ENTRY));
   assign sel_div   = (addr == ADDR_W'(A_DIV));
   assign sel_init  = (addr == ADDR_W'(A_INIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec      <= '0;
         mask     <= 1'b1;
         mode_q   <= TM_SINGLE;
         div_code <= '0;
         init_val <= '0;
      end else if (wr_en) begin
         if (sel_entry) begin
            vec    <= wdata[VEC_W-1:0];
            mask   <= wdata[MASK_BIT];
            mode_q <= tmr_mode_e'(wdata[ENTRY_TOP:MODE_LO]);
         end
         if (sel_div)
            div_code <= {wdata[3], wdata[1], wdata[0]};
         if (sel_init)
            init_val <= wdata;
      end
   end

   // only the repeating encoding reloads; deadline and reserved act single-shot
   assign periodic = (mode_q == TM_REPEAT);
   assign arm      = wr_en && sel_init && (|wdata);
   assign stop     = wr_en && sel_init && !(|wdata);

   always_comb begin
      rd_next = '0;
      unique case (addr[1:0])
         A_ENTRY: begin
            rd_next[VEC_W-1:0]          = vec;
            rd_next[MASK_BIT]           = mask;
            rd_next[ENTRY_TOP:MODE_LO]  = mode_q;
         end
         A_DIV: begin
            rd_next[3] = div_code[2];
            rd_next[1] = div_code[1];
            rd_next[0] = div_code[0];
         end
         A_INIT:  rd_next = init_val;
         A_CUR:   rd_next = cur_val;
         default: rd_next = '0;
      endcase
      if (addr != ADDR_W'(addr[1:0]))
         rd_next = '0;
   end

   generate
      if (RD_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_next;
         end
      end else begin : g_rd_comb
         assign rdata = rd_next;
      end
   endgenerate
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic [2:0] div_code,
   output logic       tick
);
   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] low_mask;
   logic [2:0]       shift;

   assign shift    = code_to_shift(div_code);
   assign low_mask = PRE_W'((8'd1 << shift) - 8'd1);
   assign tick     = run && ((pcnt & low_mask) == low_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (run)     pcnt <= pcnt + PRE_W'(1);
   end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             stop,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_val,
   input  logic             tick,
   input  logic             periodic,
   input  logic             mask,
   input  logic [VEC_W-1:0] vec,
   output logic [CNT_W-1:0] cur_val,
   output logic             running,
   output logic             irq_pulse,
   output logic [VEC_W-1:0] irq_vec
);
   logic at_last;
   logic expire;

   assign at_last = (cur_val == CNT_W'(1));
   assign expire  = !arm && !stop && running && tick && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_val <= '0;
         running <= 1'b0;
      end else if (arm) begin
         cur_val <= load_val;
         running <= 1'b1;
      end else if (stop) begin
         cur_val <= '0;
         running <= 1'b0;
      end else if (running && tick) begin
         if (at_last) begin
            cur_val <= periodic ? init_val : '0;
            running <= periodic;
         end else begin
            cur_val <= cur_val - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pulse <= 1'b0;
         irq_vec   <= '0;
      end else begin
         irq_pulse <= expire && !mask;
         irq_vec   <= (expire && !mask) ? vec : '0;
      end
   end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 2,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic [CNT_W-1:0]  cfg_rdata,
   output logic              irq_pulse,
   output logic [VEC_W-1:0]  irq_vec
);
   generate
      if (CNT_W < 19) begin : g_bad_cnt
         $error("CNT_W must hold the timer entry fields (>= 19)");
      end
      if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
         $error("VEC_W must be 1..16");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic [VEC_W-1:0] ent_vec;
   logic             ent_mask;
   logic             ent_periodic;
   logic [2:0]       div_code;
   logic [CNT_W-1:0] init_val;
   logic [CNT_W-1:0] cur_val;
   logic             arm, stop, tick, run_q;

   tmr_regs #(
      .CNT_W(CNT_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .RD_REG(RD_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
      .wdata(cfg_wdata), .cur_val(cur_val), .rdata(cfg_rdata),
      .vec(ent_vec), .mask(ent_mask), .periodic(ent_periodic),
      .div_code(div_code), .init_val(init_val), .arm(arm), .stop(stop)
   );

   tmr_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .restart(arm || stop), .run(run_q),
      .div_code(div_code), .tick(tick)
   );

   tmr_core #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_core (
      .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop),
      .load_val(cfg_wdata), .init_val(init_val), .tick(tick),
      .periodic(ent_periodic), .mask(ent_mask), .vec(ent_vec),
      .cur_val(cur_val), .running(run_q),
      .irq_pulse(irq_pulse), .irq_vec(irq_vec)
   );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [CNT_W-1:0]  cfg_wdata,
   input logic              irq_pulse,
   input logic [VEC_W-1:0]  irq_vec,
   input logic [CNT_W-1:0]  cur_val,
   input logic              run_q,
   input logic              ent_mask,
   input logic [CNT_W-1:0]  init_val
);
   logic wr_init, wr_cur;
   assign wr_init = cfg_wr_en && (cfg_addr == ADDR_W'(A_INIT));
   assign wr_cur  = cfg_wr_en && (cfg_addr == ADDR_W'(A_CUR));

   AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_pulse |-> irq_vec == '0);  // R5
   AST_PULSE_AFTER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(cur_val) == CNT_W'(1));  // R5
   AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cur_val != '0 && cur_val <= init_val));  // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_init) |=> $stable(cur_val));  // R6
   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !$past(ent_mask));  // R8
   AST_ZERO_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_init && cfg_wdata == '0) |=> (cur_val == '0 && !run_q && !irq_pulse));  // R9
   AST_CUR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cur && !run_q) |=> $stable(cur_val));  // R10
endmodule

bind irq_countdown_timer tmr_checker #(
   .CNT_W(CNT_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .irq_pulse(irq_pulse), .irq_vec(irq_vec),
   .cur_val(cur_val), .run_q(run_q), .ent_mask(ent_mask), .init_val(init_val)
);

// File: tb/irq_countdown_timer_test.sv
`timescale 1ns/1ps
module irq_countdown_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq_pulse;
   logic [7:0]  irq_vec;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   irq_countdown_timer uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .irq_pulse(irq_pulse), .irq_vec(irq_vec)
   );

   function automatic int div_of(input logic [2:0] code);
      return (code == 3'b111) ? 1 : (1 << (int'(code) + 1));
   endfunction

   function automatic logic [31:0] div_reg(input logic [2:0] code);
      return {28'd0, code[2], 1'b0, code[1], code[0]};
   endfunction

   function automatic int exp_cur(input int n, input int d, input bit per, input int m);
      if (!per && m >= n * d) return 0;
      return n - ((m % (n * d)) / d);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   // called at the negedge right after the start-value write edge
   task automatic monitor(input int n, input int d, input bit per, input bit msk,
                          input logic [7:0] v, input int horizon, input string tag);
      logic [31:0] c;
      for (int m = 1; m <= horizon; m++) begin
         bit ep;
         @(negedge clk);
         ep = !msk && (m % (n * d) == 0) && (per || m == n * d);
         chk({tag, " pulse"}, {31'd0, irq_pulse}, {31'd0, ep});
         chk({tag, " vector"}, {24'd0, irq_vec}, ep ? {24'd0, v} : 32'd0);
         rd(2'd3, c);
         chk({tag, " R4 count"}, c, 32'(exp_cur(n, d, per, m)));
      end
   endtask

   task automatic run_case(input int n, input logic [2:0] code, input logic [1:0] mode,
                           input bit msk, input logic [7:0] v, input string tag);
      int d;
      d = div_of(code);
      wr(2'd2, 32'd0);
      wr(2'd0, {13'd0, mode, msk, 8'd0, v});
      wr(2'd1, div_reg(code));
      wr(2'd2, 32'(n));
      monitor(n, d, mode == 2'b01, msk, v, 2 * n * d + 3, tag);
   endtask

   initial begin
      #(190000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h1a2b3c4d));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, r); chk("R1 entry", r, 32'h0001_0000);
      rd(2'd1, r); chk("R1 divider", r, 32'd0);
      rd(2'd2, r); chk("R1 start", r, 32'd0);
      rd(2'd3, r); chk("R1 current", r, 32'd0);
      chk("R1 irq", {31'd0, irq_pulse}, 32'd0);

      // R2 / R3 field readback
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, r); chk("R2 entry fields", r, 32'h0007_00FF);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, r); chk("R3 divider bits", r, 32'h0000_000B);
      wr(2'd1, 32'h0000_0004); rd(2'd1, r); chk("R3 bit2 dropped", r, 32'd0);

      // R10 current count not writable
      wr(2'd3, 32'h0000_1234); rd(2'd3, r); chk("R10 write ignored", r, 32'd0);

      // directed cases
      run_case(5, 3'b111, 2'b00, 1'b0, 8'h41, "R5 R6 single");
      run_case(3, 3'b011, 2'b00, 1'b0, 8'h77, "R3 div16");
      run_case(4, 3'b000, 2'b01, 1'b0, 8'h99, "R7 repeat");
      run_case(6, 3'b001, 2'b01, 1'b1, 8'h22, "R8 masked");
      run_case(4, 3'b111, 2'b10, 1'b0, 8'h5A, "R12 deadline");
      run_case(1, 3'b111, 2'b01, 1'b0, 8'h03, "R7 every cycle");

      // R10 while running: write to current count must not disturb the count
      wr(2'd2, 32'd0);
      wr(2'd0, {13'd0, 2'b00, 1'b0, 8'd0, 8'h11});
      wr(2'd1, div_reg(3'b111));
      wr(2'd2, 32'd40);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'd3;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      rd(2'd3, r); chk("R10 running", r, 32'd38);

      // R9 zero halts
      wr(2'd2, 32'd0);
      wr(2'd0, {13'd0, 2'b01, 1'b0, 8'd0, 8'h33});
      wr(2'd1, div_reg(3'b111));
      wr(2'd2, 32'd100);
      monitor(100, 1, 1'b1, 1'b0, 8'h33, 10, "R4 pre-halt");
      wr(2'd2, 32'd0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         rd(2'd3, r);
         chk("R9 count zero", r, 32'd0);
         chk("R9 no pulse", {31'd0, irq_pulse}, 32'd0);
      end

      // R11 restart while running
      wr(2'd0, {13'd0, 2'b00, 1'b0, 8'd0, 8'h44});
      wr(2'd2, 32'd50);
      monitor(50, 1, 1'b0, 1'b0, 8'h44, 10, "R11 first");
      wr(2'd2, 32'd7);
      monitor(7, 1, 1'b0, 1'b0, 8'h44, 20, "R11 restart");

      // constrained random mix
      for (int k = 0; k < 24; k++) begin
         int          n;
         logic [2:0]  code;
         logic [1:0]  mode;
         bit          msk;
         logic [7:0]  v;
         string       tag;
         n    = 1 + int'($urandom % 10);
         code = 3'($urandom);
         mode = 2'($urandom % 3);
         msk  = ($urandom % 4) == 0;
         v    = 8'($urandom);
         tag  = msk ? "R8 rand" : (mode == 2'b01 ? "R7 rand" : "R6 rand");
         run_case(n, code, mode, msk, v, tag);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule